// File: doc/BRIEF.md
# Per-Thread Interrupt Vector Receiver

This block keeps the pending-interrupt state of one hardware thread. A sender posts a vector number in the range 0 to 63 through a posting port. The block records it as one bit in a 64-bit pending bitmap, and that bitmap is visible on an output at all times. Observing the bitmap never changes it.

A separate claim port serves the interrupt handler. When the handler asserts a claim, the block presents the number of the highest pending vector in plain binary in the same cycle. It then drops that vector's pending bit at the clock edge that ends the claim. While any bit is pending, the block holds a trap request to the thread, together with a fixed trap-type code.

Top module: `intvec_rx_unit`

## Requirements
- R1: A post (`post_valid` high with `post_vec` = v) sets bit v of `pend_map` at the next rising edge. Posting vector 5 into an empty map makes `pend_map` read 0x20.
- R2: In a cycle with neither a post nor a claim, `pend_map` keeps its value. Observing `pend_map` has no side effect.
- R3: `claim_vec` is the index of the highest set bit of `pend_map`, given as an unsigned binary number, in the same cycle.
- R4: A claim (`claim_req` high while a bit is pending) clears the bit whose number `claim_vec` shows. The clear takes effect at the next rising edge and leaves every other bit alone.
- R5: With no vector pending, both `pend_map` and `claim_vec` are zero.
- R6: `trap_req` is high exactly while at least one bit of `pend_map` is set. It falls in the cycle after the last bit clears. `trap_code` always reads 0x60.
- R7: If a post and a claim name the same vector in the same cycle, that vector's bit is still set afterwards. A post of a different vector alongside a claim takes effect as well.
- R8: Posting a vector that is already pending leaves `pend_map` unchanged. A single claim then empties that bit.
- R9: Reset (`rst_n` low) clears the whole map and drops `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Posts the vector on `post_vec` this cycle |
| post_vec | input | 6 | Vector number to mark pending |
| claim_req | input | 1 | Claims the vector shown on `claim_vec` and clears its bit |
| claim_vec | output | 6 | Highest pending vector number, zero when none is pending |
| pend_map | output | 64 | Pending bitmap, bit v set when vector v is pending |
| trap_req | output | 1 | Trap request to the owning thread |
| trap_code | output | 8 | Trap type carried with the request (0x60) |

## Verification
The hardest case to reach is a post that lands in the same cycle as a claim of the very same vector. A normal handler claims only after seeing the request, so this overlap needs deliberate timing. The stimulus first posts vector 9. It then asserts `claim_req` and a second post of vector 9 in one cycle, and checks that the claim returned 9 and that bit 9 is still pending afterwards. It then repeats the overlap with a post of a different vector, which must be added while the claimed bit leaves the map.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  localparam int DEF_NUM_VEC   = 64;
  localparam int DEF_TRAP_W    = 8;
  localparam int DEF_TRAP_TYPE = 'h60;

  // Kind of access seen by the bitmap in one cycle.
  typedef enum logic [1:0] {
    ACC_IDLE = 2'b00,
    ACC_SET  = 2'b01,
    ACC_CLR  = 2'b10,
    ACC_BOTH = 2'b11
  } acc_e;

  function automatic acc_e acc_kind(input logic do_set, input logic do_clr);
    return acc_e'({do_clr, do_set});
  endfunction

endpackage

// File: rtl/intvec_onehot.sv
module intvec_onehot #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic         en,
  input  logic [W-1:0] idx,
  output logic [N-1:0] onehot
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign onehot[g] = en && (idx == W'(g));
  end

endmodule

// File: rtl/intvec_prio.sv
module intvec_prio #(
  parameter int N = 64,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] map,
  output logic [W-1:0] top_idx,
  output logic         any
);

  // Ascending scan: the last set bit seen is the highest one.
  function automatic logic [W-1:0] highest(input logic [N-1:0] m);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) r = W'(i);
    end
    return r;
  endfunction

  assign top_idx = highest(map);
  assign any     = |map;

endmodule

// File: rtl/intvec_bitmap.sv
module intvec_bitmap
  import intvec_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] map_q
);

  acc_e         acc;
  logic [N-1:0] map_d;

  assign acc   = acc_kind(|set_mask, |clr_mask);
  // A set beats a clear on the same bit.
  assign map_d = (map_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_IDLE) |=> $stable(map_q)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_BOTH) |=> ((map_q & $past(set_mask)) == $past(set_mask))); // R7
  AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_CLR) |=> ($countones(map_q) + 1 == $countones($past(map_q)))); // R4

endmodule

// File: rtl/intvec_rx_unit.sv
module intvec_rx_unit
  import intvec_pkg::*;
#(
  parameter int NUM_VEC   = DEF_NUM_VEC,
  parameter int TRAP_W    = DEF_TRAP_W,
  parameter int TRAP_TYPE = DEF_TRAP_TYPE,
  localparam int VEC_W    = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_valid,
  input  logic [VEC_W-1:0]   post_vec,
  input  logic               claim_req,
  output logic [VEC_W-1:0]   claim_vec,
  output logic [NUM_VEC-1:0] pend_map,
  output logic               trap_req,
  output logic [TRAP_W-1:0]  trap_code
);

  logic [NUM_VEC-1:0] set_mask;
  logic [NUM_VEC-1:0] clr_mask;
  logic [VEC_W-1:0]   top_idx;
  logic               any_pend;
  logic               claim_fire;

  assign claim_fire = claim_req && any_pend;

  intvec_onehot #(.N(NUM_VEC)) u_set_dec (
    .en     (post_valid),
    .idx    (post_vec),
    .onehot (set_mask)
  );

  intvec_onehot #(.N(NUM_VEC)) u_clr_dec (
    .en     (claim_fire),
    .idx    (top_idx),
    .onehot (clr_mask)
  );

  intvec_bitmap #(.N(NUM_VEC)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .map_q    (pend_map)
  );

  intvec_prio #(.N(NUM_VEC)) u_prio (
    .map     (pend_map),
    .top_idx (top_idx),
    .any     (any_pend)
  );

  assign claim_vec = top_idx;
  assign trap_req  = any_pend;
  assign trap_code = TRAP_W'(TRAP_TYPE);

  AST_POST_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |=> pend_map[$past(post_vec)]); // R1
  AST_TOP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> ((pend_map >> claim_vec) == NUM_VEC'(1))); // R3
  AST_CLAIM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_fire && !(post_valid && post_vec == claim_vec)) |=> !pend_map[$past(claim_vec)]); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> (claim_vec == '0)); // R5
  AST_TRAP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trap_req) |-> ($past(claim_req) && !$past(post_valid))); // R6

endmodule

// File: tb/intvec_rx_unit_tb_top.sv
module intvec_rx_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          post_valid = 1'b0;
  logic [5:0]    post_vec = '0;
  logic          claim_req = 1'b0;
  logic [5:0]    claim_vec;
  logic [NV-1:0] pend_map;
  logic          trap_req;
  logic [7:0]    trap_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intvec_rx_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_valid (post_valid),
    .post_vec   (post_vec),
    .claim_req  (claim_req),
    .claim_vec  (claim_vec),
    .pend_map   (pend_map),
    .trap_req   (trap_req),
    .trap_code  (trap_code)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Downward search for the top pending vector.
  function automatic logic [5:0] top_of(input logic [NV-1:0] m);
    int i = NV - 1;
    while (i > 0 && !m[i]) i--;
    return 6'(i);
  endfunction

  task automatic post(input int v);
    @(negedge clk);
    post_valid = 1'b1; post_vec = 6'(v);
    @(negedge clk);
    post_valid = 1'b0;
  endtask

  task automatic claim(input string req, input logic [5:0] exp_v);
    @(negedge clk);
    claim_req = 1'b1;
    #1 check(req, 64'(claim_vec), 64'(exp_v));
    @(negedge clk);
    claim_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 map after reset", pend_map, 64'h0);
    check("R9 trap after reset", 64'(trap_req), 64'h0);
    check("R5 claim_vec empty", 64'(claim_vec), 64'h0);
    check("R6 trap_code", 64'(trap_code), 64'h60);
  endtask

  task automatic t_single();
    post(5);
    check("R1 map after post 5", pend_map, 64'h20);
    check("R6 trap high", 64'(trap_req), 64'h1);
    @(negedge clk); @(negedge clk);
    check("R2 map stable idle", pend_map, 64'h20);
    claim("R3 claim returns 5", 6'd5);
    check("R4 bit 5 cleared", pend_map, 64'h0);
    check("R6 trap fell after last clear", 64'(trap_req), 64'h0);
    check("R5 claim_vec zero", 64'(claim_vec), 64'h0);
  endtask

  task automatic t_multi();
    logic [NV-1:0] m = '0;
    int vs[4] = '{3, 40, 63, 0};
    foreach (vs[k]) begin
      post(vs[k]);
      m[vs[k]] = 1'b1;
    end
    check("R1 map with four posts", pend_map, m);
    for (int k = 0; k < 4; k++) begin
      claim("R3 highest first", top_of(m));
      m[top_of(m)] = 1'b0;
      check("R4 only claimed bit dropped", pend_map, m);
    end
    check("R6 trap low when empty", 64'(trap_req), 64'h0);
  endtask

  task automatic t_dup();
    post(7);
    post(7);
    check("R8 repeat post unchanged", pend_map, 64'h80);
    claim("R8 claim 7", 6'd7);
    check("R8 one claim empties", pend_map, 64'h0);
    check("R8 trap low", 64'(trap_req), 64'h0);
  endtask

  task automatic t_collide();
    post(9);
    @(negedge clk);
    claim_req = 1'b1; post_valid = 1'b1; post_vec = 6'd9;
    #1 check("R7 claim sees 9", 64'(claim_vec), 64'd9);
    @(negedge clk);
    claim_req = 1'b0; post_valid = 1'b0;
    check("R7 same-vector post survives", pend_map, 64'h200);
    check("R7 trap still high", 64'(trap_req), 64'h1);
    @(negedge clk);
    claim_req = 1'b1; post_valid = 1'b1; post_vec = 6'd2;
    #1 check("R7 claim sees 9 again", 64'(claim_vec), 64'd9);
    @(negedge clk);
    claim_req = 1'b0; post_valid = 1'b0;
    check("R7 other post lands, 9 cleared", pend_map, 64'h4);
    claim("R3 claim 2", 6'd2);
    check("R4 empty", pend_map, 64'h0);
  endtask

  task automatic t_reset_mid();
    post(12); post(50);
    check("R1 two pending", pend_map, (64'h1 << 50) | (64'h1 << 12));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 map cleared by reset", pend_map, 64'h0);
    check("R9 trap cleared by reset", 64'(trap_req), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_dup();
    t_collide();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule